// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets clocked logic read and write an external asynchronous static RAM of 128K sixteen-bit words. Each word has two byte lanes, and each lane has its own active-low enable. The user side is a valid/ready request port. A request carries a direction flag, a word address, write data and a two-bit lane mask. Read results come back on a plain data bus with a one-cycle valid flag, and a one-cycle acknowledge marks the end of every transfer. On the memory side the block drives the address, an active-low chip select, a write strobe, an output strobe and one enable per lane. The bidirectional data bus is split into an outgoing word, a drive enable and an incoming word, so the tristate buffer stays in the pad ring.

Each transfer runs through four phases. An address phase puts the address and lanes on the pins with chip select low. A strobe phase holds the write or output strobe low. A recovery phase returns every strobe high, and then the block goes back to idle. The length of each phase is a parameter counted in clock cycles. The default values meet the fast memory grade's timing minimums at a 125 MHz clock.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester that finds `req_ready` low keeps `req_valid` and every request field steady until the request is taken. Read data has no back-pressure: the result must be taken in the cycle `rd_valid` is high.

Top module: `sram_bridge`

## Requirements
- R1: While reset is low and in the first cycle after it, chip select, both strobes and both lane enables are high, the data drive enable is low, `req_ready` is high, and `ack` and `rd_valid` are low.
- R2: `req_ready` is high exactly when no transfer is in flight. A request that is held valid during a transfer is not taken until the cycle in which `ack` is high.
- R3: For a write with a non-zero mask, the cycle after acceptance starts 1 address cycle with chip select low and both strobes high. Then come 6 cycles with the write strobe low. The output strobe stays high for the whole write, so the write happens only in the overlap of chip select and the write strobe.
- R4: `mem_addr` shows the accepted word address while chip select is low, and it does not change while chip select stays low.
- R5: Mask bit 0 enables the lane for data bits 7:0 on `mem_be_n[0]`, and mask bit 1 enables the lane for bits 15:8 on `mem_be_n[1]`. Both enables are active low. A lane is enabled during the address and strobe phases only if its mask bit is 1. A write on one lane leaves the other byte of the word unchanged.
- R6: For a read with a non-zero mask, the address cycle is followed by 7 cycles with the output strobe low and the write strobe high. The input word is registered at the end of the last of those cycles, with the bytes of disabled lanes forced to zero. `rd_valid` is high for exactly the one cycle that follows.
- R7: `mem_dq_oe` is high only during the strobe phase of a write, while chip select and the write strobe are low and the output strobe is high. `mem_dq_out` then carries the accepted write data.
- R8: Every strobe phase, and every empty-mask request, is followed by 3 recovery cycles with all strobes and lane enables high. `ack` is then high for one cycle, in the first idle cycle.
- R9: A request with mask 00 never lowers chip select, a strobe or a lane enable. It never drives the bus and never raises `rd_valid`. Its `ack` comes 4 cycles after acceptance.
- R10: At 8 ns per cycle the default counts give these minimums: write strobe pulse 40 ns, chip select low to end of write 45 ns, data driven before end of write 25 ns, chip select low to read sample 55 ns, output strobe low to read sample 25 ns. Between the output strobe going high and the next time the bus is driven there are at least 25 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle pulse at the end of each transfer |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 16 | Read data, zero in disabled lanes |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
On every cycle the assertions check these protocol rules: the bus is driven only inside a write overlap with the output strobe high, the two strobes are never low together, the address is steady while chip select is low, no lane is enabled without chip select, and `ack` and `rd_valid` each last one cycle. The bench's scenarios are what show the rest. They cover the exact phase lengths, read-back of partially written words through its memory model, zeroed disabled lanes, silent completion of empty masks, hold-off of a waiting request, and the nanosecond margins measured from pulse widths and bus turnaround gaps.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  function automatic int unsigned max_of4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_bridge_pkg::*;
#(
  parameter int SETUP_CYC     = 1,
  parameter int WR_STROBE_CYC = 6,
  parameter int RD_STROBE_CYC = 7,
  parameter int RECOVER_CYC   = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_empty,
  input  logic   op_write,
  output phase_e phase,
  output logic   strobe_last,
  output logic   done
);
  localparam int MAXC = int'(max_of4(SETUP_CYC, WR_STROBE_CYC, RD_STROBE_CYC, RECOVER_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LV_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LV_WR    = CW'(WR_STROBE_CYC - 1);
  localparam logic [CW-1:0] LV_RD    = CW'(RD_STROBE_CYC - 1);
  localparam logic [CW-1:0] LV_RCV   = CW'(RECOVER_CYC - 1);

  phase_e        phase_nx;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    phase_nx = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        load = 1'b1;
        if (start_empty) begin
          phase_nx = PH_RECOVER;
          load_val = LV_RCV;
        end else begin
          phase_nx = PH_SETUP;
          load_val = LV_SETUP;
        end
      end
      PH_SETUP: if (expired) begin
        phase_nx = PH_STROBE;
        load     = 1'b1;
        load_val = op_write ? LV_WR : LV_RD;
      end
      PH_STROBE: if (expired) begin
        phase_nx = PH_RECOVER;
        load     = 1'b1;
        load_val = LV_RCV;
      end
      PH_RECOVER: if (expired) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phase_nx;
      done  <= (phase == PH_RECOVER) && expired;
    end
  end

  assign strobe_last = (phase == PH_STROBE) && expired;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    capture,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n[g] = ~(active & mask[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rd_word[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rd_word[g*LANE_W +: LANE_W] <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int LANES         = 2,
  parameter int LANE_W        = 8,
  parameter int SETUP_CYC     = 1,
  parameter int WR_STROBE_CYC = 6,
  parameter int RD_STROBE_CYC = 7,
  parameter int RECOVER_CYC   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic                    ack,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_be_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);
  localparam int DATA_W = LANES * LANE_W;

  phase_e              phase;
  logic                accept;
  logic                strobe_last;
  logic                wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_q;
  logic                sel_active;
  logic                in_strobe;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  sram_seq #(
    .SETUP_CYC     (SETUP_CYC),
    .WR_STROBE_CYC (WR_STROBE_CYC),
    .RD_STROBE_CYC (RD_STROBE_CYC),
    .RECOVER_CYC   (RECOVER_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_empty (req_mask == '0),
    .op_write    (wr_q),
    .phase       (phase),
    .strobe_last (strobe_last),
    .done        (ack)
  );

  assign in_strobe  = (phase == PH_STROBE);
  assign sel_active = (phase == PH_SETUP) || in_strobe;

  sram_lane_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (sel_active),
    .capture (strobe_last && !wr_q),
    .mask    (mask_q),
    .dq_in   (mem_dq_in),
    .be_n    (mem_be_n),
    .rd_word (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= strobe_last && !wr_q;
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ~sel_active;
  assign mem_we_n   = ~(in_strobe && wr_q);
  assign mem_oe_n   = ~(in_strobe && !wr_q);
  assign mem_dq_oe  = in_strobe && wr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ack,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe && !ack && !rd_valid));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_we_within_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_lane_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_be_n) |-> !mem_ce_n);

  assert_rdvalid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_drive_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ce_has_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(&mem_be_n));
endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ack       (ack),
  .rd_valid  (rd_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;
  localparam int NS_PER_CYC = 8;
  localparam int S_CYC = 1, W_CYC = 6, R_CYC = 7, C_CYC = 3;

  typedef struct {
    logic        ready, ce_n, we_n, oe_n, dq_oe, ack, rd_valid, chk_addr;
    logic [1:0]  be_n;
    logic [15:0] rd_data, dq;
    logic [16:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, ack, rd_valid;
  logic [15:0] rd_data, mem_dq_out;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_in = 16'hBEEF;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  exp_t q[$];
  logic [15:0] mem [logic [16:0]];

  sram_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] model_rd(input logic [16:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h3C};
  endfunction

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  function automatic exp_t idle_exp();
    exp_t e;
    e.ready = 1'b1; e.ce_n = 1'b1; e.we_n = 1'b1; e.oe_n = 1'b1; e.dq_oe = 1'b0;
    e.ack = 1'b0; e.rd_valid = 1'b0; e.chk_addr = 1'b0; e.be_n = 2'b11;
    e.rd_data = '0; e.dq = '0; e.addr = '0;
    return e;
  endfunction

  task automatic push_op(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    logic [15:0] w;
    e = idle_exp();
    e.ready = 1'b0;
    if (m != 2'b00) begin
      e.ce_n = 1'b0; e.be_n = ~m; e.chk_addr = 1'b1; e.addr = a;
      for (int i = 0; i < S_CYC; i++) q.push_back(e);
      if (wr) begin e.we_n = 1'b0; e.dq_oe = 1'b1; e.dq = d; end
      else e.oe_n = 1'b0;
      for (int i = 0; i < (wr ? W_CYC : R_CYC); i++) q.push_back(e);
    end
    for (int i = 0; i < C_CYC; i++) begin
      e = idle_exp();
      e.ready = 1'b0;
      if (i == 0 && !wr && m != 2'b00) begin
        w = model_rd(a);
        e.rd_valid = 1'b1;
        e.rd_data = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
      end
      q.push_back(e);
    end
    e = idle_exp();
    e.ack = 1'b1;
    q.push_back(e);
  endtask

  // cycle-level timing observers (R10)
  logic p_ce_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  logic [16:0] p_addr = '0;
  logic [1:0]  p_be_n = 2'b11;
  logic [15:0] p_dq = '0;
  int ce_run = 0, we_run = 0, oe_run = 0, dq_run = 0, oe_high_run = 1000;

  always @(negedge clk) begin
    exp_t e;
    string rq;
    logic [15:0] w;
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    e = (q.size() > 0) ? q.pop_front() : idle_exp();
    rq = rst_n ? "" : "R1 ";
    check({rq, "R2"}, "req_ready", req_ready, e.ready);
    check({rq, "R3"}, "mem_ce_n", mem_ce_n, e.ce_n);
    check({rq, "R3"}, "mem_we_n", mem_we_n, e.we_n);
    check({rq, "R6"}, "mem_oe_n", mem_oe_n, e.oe_n);
    check({rq, "R5"}, "mem_be_n", mem_be_n, e.be_n);
    check({rq, "R7"}, "mem_dq_oe", mem_dq_oe, e.dq_oe);
    check({rq, "R8"}, "ack", ack, e.ack);
    check({rq, "R6"}, "rd_valid", rd_valid, e.rd_valid);
    if (e.rd_valid) check("R6", "rd_data", rd_data, e.rd_data);
    if (e.chk_addr) check("R4", "mem_addr", mem_addr, e.addr);
    if (e.dq_oe)    check("R7", "mem_dq_out", mem_dq_out, e.dq);

    // memory model: write commits when the chip-select/write-strobe overlap ends
    if (!p_ce_n && !p_we_n && !(!mem_ce_n && !mem_we_n)) begin
      w = model_rd(p_addr);
      if (!p_be_n[0]) w[7:0]  = p_dq[7:0];
      if (!p_be_n[1]) w[15:8] = p_dq[15:8];
      mem[p_addr] = w;
    end

    // R10 timing margins, measured in elapsed cycles
    if (!p_we_n && mem_we_n) begin
      check("R10", "write pulse ns>=40", 32'(we_run * NS_PER_CYC >= 40), 1);
      check("R10", "ce low to write end ns>=45", 32'(ce_run * NS_PER_CYC >= 45), 1);
      check("R10", "data setup ns>=25", 32'(dq_run * NS_PER_CYC >= 25), 1);
    end
    if (!p_oe_n && mem_oe_n) begin
      check("R10", "ce low to sample ns>=55", 32'(ce_run * NS_PER_CYC >= 55), 1);
      check("R10", "oe low to sample ns>=25", 32'(oe_run * NS_PER_CYC >= 25), 1);
    end
    if (!p_dq_oe && mem_dq_oe)
      check("R10", "turnaround ns>=25", 32'(oe_high_run * NS_PER_CYC >= 25), 1);

    ce_run      = mem_ce_n ? 0 : ce_run + 1;
    we_run      = mem_we_n ? 0 : we_run + 1;
    oe_run      = mem_oe_n ? 0 : oe_run + 1;
    dq_run      = mem_dq_oe ? dq_run + 1 : 0;
    oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
    p_ce_n = mem_ce_n; p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
    p_addr = mem_addr; p_be_n = mem_be_n; p_dq = mem_dq_out;

    // memory drives the bus only for a read; disabled lanes carry junk
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      w = model_rd(mem_addr);
      mem_dq_in <= {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'h5A : w[7:0]};
    end else mem_dq_in <= 16'hBEEF;

    if (rst_n && req_valid && req_ready) push_op(req_write, req_addr, req_wdata, req_mask);
  end

  task automatic do_op(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    do_op(1, 17'h00010, 16'h1234, 2'b11);   // R3 full write
    do_op(0, 17'h00010, 16'h0000, 2'b11);   // R6 read back
    do_op(1, 17'h00010, 16'hABCD, 2'b01);   // R5 low lane only
    do_op(0, 17'h00010, 16'h0000, 2'b11);
    repeat (3) @(posedge clk);
    #1;
    do_op(1, 17'h00010, 16'h77EE, 2'b10);   // R5 high lane only
    do_op(0, 17'h00010, 16'h0000, 2'b01);   // R6 disabled lane reads zero
    do_op(0, 17'h00010, 16'h0000, 2'b10);
    do_op(1, 17'h00010, 16'hFFFF, 2'b00);   // R9 empty mask write
    do_op(0, 17'h00010, 16'h0000, 2'b00);   // R9 empty mask read
    do_op(0, 17'h00010, 16'h0000, 2'b11);
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11);   // R4 top address
    do_op(1, 17'h1FFFF, 16'h0F0F, 2'b11);
    do_op(1, 17'h00000, 16'hC001, 2'b11);   // R2 back-to-back hold-off
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_op(0, 17'h00000, 16'h0000, 2'b11);
    repeat (20) @(posedge clk);
    #1;
    check("R1", "queue drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule